// File: doc/BRIEF.md
# Configuration Readback Serial Controller

This block streams a frame-organised configuration memory out on one serial pin. It is started by a trigger and advanced by a readback clock. A rising trigger raises the in-progress flag. The block then sends a fixed lead-in of high dummy bits. Each memory frame follows, preceded by a low start bit. After the last frame come one more low start bit and an 11-bit CRC signature, and then the flag drops. Frame memory is read through a synchronous port that returns one whole frame word per request, one cycle after the request.

Some bit positions are forced high whatever the memory holds. Other positions can be replaced by sampled live values when the capture option is set. When the abort variant is built, releasing the trigger ends a readback early. The block then re-initialises for a fixed number of clocks before it accepts a new trigger. A receiver can rebuild every frame from the stream, because the position of each kind of bit is fixed by the frame count and frame length parameters.

Top module: `cfg_readback_ser`

## Requirements
- R1: While reset is held and after its release, the in-progress flag is 0, the serial output is 1 and no frame read is requested.
- R2: A 0-to-1 change of the trigger seen at a clock edge while idle raises the in-progress flag at that edge. The next five edges each put out a 1 (dummy bits).
- R3: After the dummy bits, each frame is sent as one 0 start bit followed by FRAME_BITS data bits, least significant bit of the frame word first. Frames go in index order 0 to FRAMES-1, and the frame word comes from memory address equal to the frame index.
- R4: Data bits 0 and 1 of frame 0 are always sent as 1.
- R5: The last four data bits of every frame (indices FRAME_BITS-4 to FRAME_BITS-1) are always sent as 1.
- R6: The last seven data bits of the final frame (indices FRAME_BITS-7 to FRAME_BITS-1) are always sent as 1.
- R7: After the final frame the block sends one 0 start bit and then 11 CRC bits, most significant first. The in-progress flag drops at the edge after the last CRC bit, with the output returning to 1. The CRC register is cleared at each accepted trigger. For each data bit d as sent (start and dummy bits excluded), it updates as c = {c[9:0],0} XOR (POLY if d XOR c[10]), with POLY = 11'h385 by default.
- R8: When capture is enabled at the accepted trigger edge, data bits CAP_POS to CAP_POS+CAP_BITS-1 of frame k carry the inverse of live input bit k*CAP_BITS+j, latched at that edge, where j is the offset from CAP_POS. When capture is disabled those positions carry the stored frame bits.
- R9: With the abort variant built, a 1-to-0 change of the trigger seen at an edge during the dummy, start, data or CRC phase drives the output to 1 at that edge. The flag stays 1 for FRAMES further edges and then drops, and a trigger rise during that time is ignored.
- R10: After an abort has finished, a new trigger produces a complete and correct stream.
- R11: Exactly one frame read is issued per frame in each readback. The read for each frame is issued six edges before its start bit, so each frame word is loaded into the output shift register at its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readback clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Readback trigger (rise starts, fall aborts) |
| cap_en_i | input | 1 | Capture option, sampled at the accepted trigger |
| cap_live_i | input | FRAMES*CAP_BITS | Live values sampled (inverted) at the trigger |
| mem_rd_o | output | 1 | Frame read request |
| mem_addr_o | output | FIW | Frame index being read |
| mem_data_i | input | FRAME_BITS | Frame word, valid one clock after the request |
| sdata_o | output | 1 | Serial readback data |
| rip_o | output | 1 | Readback in progress |

## Verification
The in-design checks assume that the frame memory answers a read with the addressed word on the following clock, and that the word stays stable until the next read. The bench memory model does exactly that, and frame contents change only while the block is idle. They also assume the trigger is a clean level that does not fall during a complete readback unless an abort is intended. The stimulus therefore holds the trigger high through every full run. It lowers the trigger only in the abort cases and after the flag has dropped, and it changes inputs mid-cycle, away from the sampling edge.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;

   localparam int DUMMY_BITS = 5;   // high bits ahead of the first start bit
   localparam int LEAD_HIGH  = 2;   // forced-high bits at the head of frame 0
   localparam int CHECK_BITS = 4;   // forced-high bits closing every frame
   localparam int TAIL_HIGH  = 7;   // forced-high bits closing the final frame
   localparam int PRELOAD    = 6;   // edges between frame read and its start bit
   localparam int CRC_W      = 11;

   typedef enum logic [2:0] {
      RB_IDLE,
      RB_DUMMY,
      RB_FSTART,
      RB_FDATA,
      RB_TSTART,
      RB_TCRC,
      RB_FINISH,
      RB_RECOVER
   } rb_state_e;

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                 input logic              din,
                                                 input logic [CRC_W-1:0] poly);
      logic fb;
      fb = din ^ cur[CRC_W-1];
      return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
   endfunction

endpackage

// File: rtl/rb_trig_sense.sv
`timescale 1ns/1ps
module rb_trig_sense #(
   parameter int FRAMES   = 4,
   parameter int CAP_BITS = 2,
   parameter bit ABORT_EN = 1'b1,
   localparam int LIVE_W  = FRAMES * CAP_BITS
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              trig_i,
   input  logic              accept_i,
   input  logic              cap_en_i,
   input  logic [LIVE_W-1:0] cap_live_i,
   output logic              rise_o,
   output logic              fall_o,
   output logic              cap_en_o,
   output logic [LIVE_W-1:0] cap_o
);

   logic trig_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         trig_q   <= 1'b0;
         cap_en_o <= 1'b0;
         cap_o    <= '0;
      end else begin
         trig_q <= trig_i;
         if (accept_i) begin
            cap_en_o <= cap_en_i;
            cap_o    <= ~cap_live_i;
         end
      end
   end

   assign rise_o = trig_i & ~trig_q;

   generate
      if (ABORT_EN) begin : g_abort
         assign fall_o = ~trig_i & trig_q;
      end else begin : g_no_abort
         assign fall_o = 1'b0;
      end
   endgenerate

   // R2
   accept_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      accept_i |-> rise_o);

   // R8
   capture_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      accept_i |=> (cap_o == ~$past(cap_live_i)));

endmodule

// File: rtl/rb_frame_loader.sv
`timescale 1ns/1ps
module rb_frame_loader #(
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  clr_i,
   input  logic                  rd_i,
   input  logic [FRAME_BITS-1:0] mem_data_i,
   input  logic                  load_i,
   input  logic                  shift_i,
   output logic                  raw_bit_o
);

   logic                  pend_q;
   logic                  vld_q;
   logic [FRAME_BITS-1:0] stage_q;
   logic [FRAME_BITS-1:0] shreg_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         pend_q  <= 1'b0;
         vld_q   <= 1'b0;
         stage_q <= '0;
         shreg_q <= '0;
      end else begin
         pend_q <= rd_i;
         if (pend_q) begin
            stage_q <= mem_data_i;
            vld_q   <= 1'b1;
         end else if (load_i) begin
            vld_q <= 1'b0;
         end
         if (load_i) begin
            shreg_q <= stage_q;
         end else if (shift_i) begin
            shreg_q <= {1'b0, shreg_q[FRAME_BITS-1:1]};
         end
      end
   end

   assign raw_bit_o = shreg_q[0];

   // R11
   load_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |-> (vld_q && !pend_q));

   // R11
   rd_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_i |-> (!vld_q && !pend_q));

endmodule

// File: rtl/rb_crc11.sv
`timescale 1ns/1ps
module rb_crc11
   import rb_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 11'h385
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic upd_i,
   input  logic bit_i,
   input  logic shift_i,
   output logic msb_o
);

   logic [CRC_W-1:0] crc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         crc_q <= '0;
      end else if (upd_i) begin
         crc_q <= crc_step(crc_q, bit_i, POLY);
      end else if (shift_i) begin
         crc_q <= {crc_q[CRC_W-2:0], 1'b0};
      end
   end

   assign msb_o = crc_q[CRC_W-1];

   // R7
   crc_mode_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(upd_i && shift_i) && !(clr_i && (upd_i || shift_i)));

   // R7
   crc_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (crc_q == '0));

endmodule

// File: rtl/cfg_readback_ser.sv
`timescale 1ns/1ps
module cfg_readback_ser
   import rb_pkg::*;
#(
   parameter int               FRAMES     = 4,
   parameter int               FRAME_BITS = 16,
   parameter int               CAP_BITS   = 2,
   parameter int               CAP_POS    = 4,
   parameter logic [CRC_W-1:0] POLY       = 11'h385,
   parameter bit               ABORT_EN   = 1'b1,
   localparam int              FIW        = (FRAMES > 1) ? $clog2(FRAMES) : 1,
   localparam int              LIVE_W     = FRAMES * CAP_BITS
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  trig_i,
   input  logic                  cap_en_i,
   input  logic [LIVE_W-1:0]     cap_live_i,
   output logic                  mem_rd_o,
   output logic [FIW-1:0]        mem_addr_o,
   input  logic [FRAME_BITS-1:0] mem_data_i,
   output logic                  sdata_o,
   output logic                  rip_o
);

   localparam int CNTW = $clog2(FRAME_BITS + FRAMES + 16);
   typedef logic [CNTW-1:0] cnt_t;
   typedef logic [FIW-1:0]  fidx_t;

   localparam cnt_t C_DUMMY_LAST  = cnt_t'(DUMMY_BITS - 1);
   localparam cnt_t C_FRAME_LAST  = cnt_t'(FRAME_BITS - 1);
   localparam cnt_t C_PRELOAD     = cnt_t'(FRAME_BITS - PRELOAD);
   localparam cnt_t C_CHECK_FIRST = cnt_t'(FRAME_BITS - CHECK_BITS);
   localparam cnt_t C_TAIL_FIRST  = cnt_t'(FRAME_BITS - TAIL_HIGH);
   localparam cnt_t C_LEAD        = cnt_t'(LEAD_HIGH);
   localparam cnt_t C_CAP_LO      = cnt_t'(CAP_POS);
   localparam cnt_t C_CAP_HI      = cnt_t'(CAP_POS + CAP_BITS);
   localparam cnt_t C_CRC_LAST    = cnt_t'(CRC_W - 1);
   localparam cnt_t C_REC_LAST    = cnt_t'(FRAMES - 1);
   localparam fidx_t F_LAST       = fidx_t'(FRAMES - 1);

   // elaboration-time parameter checks
   generate
      if (FRAMES < 1) begin : g_bad_frames
         $error("cfg_readback_ser: FRAMES must be at least 1");
      end
      if (CAP_BITS < 1) begin : g_bad_capbits
         $error("cfg_readback_ser: CAP_BITS must be at least 1");
      end
      if (CAP_POS < LEAD_HIGH) begin : g_bad_cappos
         $error("cfg_readback_ser: capture field overlaps the forced lead bits");
      end
      if (CAP_POS + CAP_BITS > FRAME_BITS - TAIL_HIGH) begin : g_bad_capend
         $error("cfg_readback_ser: capture field overlaps the forced tail bits");
      end
      if (FRAME_BITS < PRELOAD + 2) begin : g_bad_flen
         $error("cfg_readback_ser: FRAME_BITS too short for the preload window");
      end
   endgenerate

   rb_state_e st_q;
   cnt_t      bcnt_q;
   fidx_t     fidx_q;
   logic      sdata_q;

   logic              rise, fall;
   logic              accept, abort_now, in_stream;
   logic              cap_en_q;
   logic [LIVE_W-1:0] cap_q;
   logic              raw_bit, crc_msb;
   logic              rd_req, load, shift;
   logic              bit_val;
   logic [LIVE_W-1:0] cap_word;
   logic [31:0]       cap_off;

   assign in_stream = (st_q == RB_DUMMY) || (st_q == RB_FSTART) || (st_q == RB_FDATA) ||
                      (st_q == RB_TSTART) || (st_q == RB_TCRC);
   assign accept    = (st_q == RB_IDLE) && rise;
   assign abort_now = in_stream && fall;

   rb_trig_sense #(
      .FRAMES   (FRAMES),
      .CAP_BITS (CAP_BITS),
      .ABORT_EN (ABORT_EN)
   ) u_trig (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .trig_i     (trig_i),
      .accept_i   (accept),
      .cap_en_i   (cap_en_i),
      .cap_live_i (cap_live_i),
      .rise_o     (rise),
      .fall_o     (fall),
      .cap_en_o   (cap_en_q),
      .cap_o      (cap_q)
   );

   assign rd_req = accept ||
                   ((st_q == RB_FDATA) && (bcnt_q == C_PRELOAD) && (fidx_q != F_LAST) && !abort_now);
   assign load   = (st_q == RB_FSTART) && !abort_now;
   assign shift  = (st_q == RB_FDATA) && !abort_now;

   assign mem_rd_o   = rd_req;
   assign mem_addr_o = accept ? '0 : fidx_q + fidx_t'(1);

   rb_frame_loader #(
      .FRAME_BITS (FRAME_BITS)
   ) u_loader (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .clr_i      (abort_now),
      .rd_i       (rd_req),
      .mem_data_i (mem_data_i),
      .load_i     (load),
      .shift_i    (shift),
      .raw_bit_o  (raw_bit)
   );

   // data bit as sent: forced-high positions win over capture, capture over memory
   always_comb begin
      cap_off  = 32'(fidx_q) * 32'(CAP_BITS) + 32'(bcnt_q) - 32'(CAP_POS);
      cap_word = cap_q >> cap_off;
      bit_val  = raw_bit;
      if (cap_en_q && (bcnt_q >= C_CAP_LO) && (bcnt_q < C_CAP_HI)) begin
         bit_val = cap_word[0];
      end
      if ((fidx_q == '0) && (bcnt_q < C_LEAD)) begin
         bit_val = 1'b1;
      end
      if (bcnt_q >= C_CHECK_FIRST) begin
         bit_val = 1'b1;
      end
      if ((fidx_q == F_LAST) && (bcnt_q >= C_TAIL_FIRST)) begin
         bit_val = 1'b1;
      end
   end

   rb_crc11 #(
      .POLY (POLY)
   ) u_crc (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clr_i   (accept),
      .upd_i   (shift),
      .bit_i   (bit_val),
      .shift_i ((st_q == RB_TCRC) && !abort_now),
      .msb_o   (crc_msb)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q    <= RB_IDLE;
         bcnt_q  <= '0;
         fidx_q  <= '0;
         sdata_q <= 1'b1;
      end else if (abort_now) begin
         st_q    <= RB_RECOVER;
         bcnt_q  <= '0;
         sdata_q <= 1'b1;
      end else begin
         unique case (st_q)
            RB_IDLE: begin
               sdata_q <= 1'b1;
               if (rise) begin
                  st_q   <= RB_DUMMY;
                  bcnt_q <= '0;
                  fidx_q <= '0;
               end
            end
            RB_DUMMY: begin
               sdata_q <= 1'b1;
               if (bcnt_q == C_DUMMY_LAST) begin
                  st_q <= RB_FSTART;
               end else begin
                  bcnt_q <= bcnt_q + cnt_t'(1);
               end
            end
            RB_FSTART: begin
               sdata_q <= 1'b0;
               st_q    <= RB_FDATA;
               bcnt_q  <= '0;
            end
            RB_FDATA: begin
               sdata_q <= bit_val;
               if (bcnt_q == C_FRAME_LAST) begin
                  bcnt_q <= '0;
                  if (fidx_q == F_LAST) begin
                     st_q <= RB_TSTART;
                  end else begin
                     st_q   <= RB_FSTART;
                     fidx_q <= fidx_q + fidx_t'(1);
                  end
               end else begin
                  bcnt_q <= bcnt_q + cnt_t'(1);
               end
            end
            RB_TSTART: begin
               sdata_q <= 1'b0;
               st_q    <= RB_TCRC;
               bcnt_q  <= '0;
            end
            RB_TCRC: begin
               sdata_q <= crc_msb;
               if (bcnt_q == C_CRC_LAST) begin
                  st_q <= RB_FINISH;
               end else begin
                  bcnt_q <= bcnt_q + cnt_t'(1);
               end
            end
            RB_FINISH: begin
               sdata_q <= 1'b1;
               st_q    <= RB_IDLE;
            end
            RB_RECOVER: begin
               sdata_q <= 1'b1;
               if (bcnt_q == C_REC_LAST) begin
                  st_q <= RB_IDLE;
               end else begin
                  bcnt_q <= bcnt_q + cnt_t'(1);
               end
            end
            default: begin
               st_q    <= RB_IDLE;
               sdata_q <= 1'b1;
            end
         endcase
      end
   end

   assign sdata_o = sdata_q;
   assign rip_o   = (st_q != RB_IDLE);

   // R2
   rip_rise_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(rip_o) |-> (sdata_o && $past(trig_i)));

   // R5
   check_bits_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ((st_q == RB_FDATA) && (bcnt_q >= C_CHECK_FIRST)) |=> sdata_o);

   // R7
   trailer_start_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ((st_q == RB_TSTART) && !abort_now) |=> !sdata_o);

   // R9
   recover_idle_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (st_q == RB_RECOVER) |-> (sdata_o && rip_o && !mem_rd_o));

   // R7
   rip_fall_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rip_o) |-> sdata_o);

endmodule

// File: tb/cfg_readback_ser_test.sv
`timescale 1ns/1ps
module cfg_readback_ser_test;

   localparam int          NF   = 4;
   localparam int          FB   = 16;
   localparam int          CB   = 2;
   localparam int          CP   = 4;
   localparam logic [10:0] POLY = 11'h385;
   localparam int          FIW  = 2;
   localparam int          L    = 5 + NF * (FB + 1) + 1 + 11;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               trig = 1'b0;
   logic               cap_en = 1'b0;
   logic [NF*CB-1:0]   live = '0;
   logic               mem_rd;
   logic [FIW-1:0]     mem_addr;
   logic [FB-1:0]      mem_q = '0;
   logic               sdata;
   logic               rip;
   logic [FB-1:0]      frames [NF];

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   logic  exp_bit [L];
   string exp_tag [L];

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) if (mem_rd) mem_q <= frames[mem_addr];

   cfg_readback_ser #(
      .FRAMES (NF), .FRAME_BITS (FB), .CAP_BITS (CB), .CAP_POS (CP),
      .POLY (POLY), .ABORT_EN (1'b1)
   ) uut (
      .clk_i (clk), .rst_i (rst), .trig_i (trig), .cap_en_i (cap_en),
      .cap_live_i (live), .mem_rd_o (mem_rd), .mem_addr_o (mem_addr),
      .mem_data_i (mem_q), .sdata_o (sdata), .rip_o (rip)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // expected stream from the requirements
   task automatic build();
      int          n;
      logic [10:0] c;
      logic        v;
      string       t;
      n = 0;
      c = '0;
      for (int i = 0; i < 5; i++) begin exp_bit[n] = 1'b1; exp_tag[n] = "R2"; n++; end
      for (int f = 0; f < NF; f++) begin
         exp_bit[n] = 1'b0; exp_tag[n] = "R3"; n++;
         for (int b = 0; b < FB; b++) begin
            v = frames[f][b]; t = "R3";
            if (cap_en && b >= CP && b < CP + CB) begin v = ~live[f*CB + b - CP]; t = "R8"; end
            if (f == 0 && b < 2) begin v = 1'b1; t = "R4"; end
            if (b >= FB - 4) begin v = 1'b1; t = "R5"; end
            if (f == NF - 1 && b >= FB - 7) begin v = 1'b1; t = "R6"; end
            c = ({c[9:0], 1'b0}) ^ ((v ^ c[10]) ? POLY : 11'h000);
            exp_bit[n] = v; exp_tag[n] = t; n++;
         end
      end
      exp_bit[n] = 1'b0; exp_tag[n] = "R7"; n++;
      for (int k = 10; k >= 0; k--) begin exp_bit[n] = c[k]; exp_tag[n] = "R7"; n++; end
   endtask

   task automatic run_full(input string tag);
      int reads;
      build();
      @(negedge clk);
      trig = 1'b1;
      #1;
      reads = int'(mem_rd);
      @(posedge clk); #5;
      chk(rip === 1'b1, "R2", {tag, " flag after trigger"}, 32'(rip), 1);
      reads += int'(mem_rd);
      for (int i = 0; i < L; i++) begin
         @(posedge clk); #5;
         chk(sdata === exp_bit[i], exp_tag[i], $sformatf("%s bit %0d", tag, i), 32'(sdata), 32'(exp_bit[i]));
         reads += int'(mem_rd);
      end
      @(posedge clk); #5;
      chk(rip === 1'b0 && sdata === 1'b1, "R7", {tag, " flag drop"}, {30'd0, rip, sdata}, 32'b01);
      chk(reads == NF, "R11", {tag, " frame reads"}, 32'(reads), 32'(NF));
      @(negedge clk);
      trig = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic run_abort(input int k);
      @(negedge clk);
      trig = 1'b1;
      @(posedge clk);
      repeat (k) @(posedge clk);
      #5;
      trig = 1'b0;
      @(posedge clk); #5;
      chk(sdata === 1'b1 && rip === 1'b1, "R9", "abort entry", {30'd0, rip, sdata}, 32'b11);
      trig = 1'b1;   // must be ignored while recovering
      for (int j = 1; j < NF; j++) begin
         @(posedge clk); #5;
         chk(rip === 1'b1 && sdata === 1'b1, "R9", "recovery busy", {30'd0, rip, sdata}, 32'b11);
      end
      @(posedge clk); #5;
      chk(rip === 1'b0, "R9", "recovery end", 32'(rip), 0);
      for (int j = 0; j < 3; j++) begin
         @(posedge clk); #5;
         chk(rip === 1'b0 && sdata === 1'b1, "R9", "trigger ignored", {30'd0, rip, sdata}, 32'b01);
      end
      @(negedge clk);
      trig = 1'b0;
      @(posedge clk);
   endtask

   task automatic randomize_inputs(input bit cap);
      for (int f = 0; f < NF; f++) frames[f] = FB'($urandom());
      live   = (NF*CB)'($urandom());
      cap_en = cap;
   endtask

   initial begin
      void'($urandom(32'h5eed_0101));
      for (int f = 0; f < NF; f++) frames[f] = '0;
      repeat (3) @(posedge clk);
      #5;
      chk(rip === 1'b0 && sdata === 1'b1 && mem_rd === 1'b0, "R1", "in reset",
          {29'd0, rip, sdata, mem_rd}, 32'b010);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #5;
      chk(rip === 1'b0 && sdata === 1'b1 && mem_rd === 1'b0, "R1", "after reset",
          {29'd0, rip, sdata, mem_rd}, 32'b010);

      // directed: zero frames with capture of all-zero live values (R8 inverted to ones)
      for (int f = 0; f < NF; f++) frames[f] = '0;
      live = '0; cap_en = 1'b1;
      run_full("zero-cap");
      // directed: all-one frames, capture off
      for (int f = 0; f < NF; f++) frames[f] = '1;
      cap_en = 1'b0;
      run_full("ones");
      // random frames, both capture settings
      for (int r = 0; r < 6; r++) begin
         randomize_inputs(r[0]);
         run_full($sformatf("rand%0d", r));
      end
      // aborts in dummy, data and CRC phases, each followed by a full run (R10)
      run_abort(2);
      randomize_inputs(1'b1);
      run_full("R10 after dummy abort");
      run_abort(30);
      randomize_inputs(1'b0);
      run_full("R10 after data abort");
      run_abort(L - 3);
      randomize_inputs(1'b1);
      run_full("R10 after crc abort");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule